// File: doc/BRIEF.md
# Message-Object Set/Clear Control Register Bank

This block holds the software-visible control and configuration state for a set of message-object slots. Each slot has three kinds of state. There are single-bit control elements, which software drives through complementary two-bit codes. There are plain configuration fields. There are three format/routing bits whose software writes land in a shadow copy.

The two-bit codes let one bus write set some elements, clear others and leave the rest alone. No read-modify-write sequence is needed, so concurrent agents cannot lose each other's updates.

The shadow copy of the extended-identifier flag, the node-select bit and the direction bit moves into the active copy only when software sets the slot's valid element. Until then, the frame logic keeps a consistent view of the slot.

Each slot occupies a four-word window in a 16-bit register space:
- address = slot*4 + sub;
- sub 0 is the control word;
- sub 1 is configuration low;
- sub 2 is configuration high;
- sub 3 is reserved.

Writes are whole 16-bit words, taken on a clock edge when the write enable is high. Read data is a combinational function of the address.

Top module: `msgobj_ctrl_bank`

## Requirements
- R1: In a control word write, a field code of 2'b10 sets its element and 2'b01 clears it. The fields are: valid at bits [1:0], receive-pending at [3:2], transmit-request at [5:4] and message-lost at [7:6].
- R2: A control field written with 2'b11 or 2'b00 leaves its element unchanged.
- R3: Reading a control word returns 2'b01 in a field whose element is clear and 2'b10 in a field whose element is set. A read never returns 2'b00 or 2'b11.
- R4: The fields of one control write act independently, so one write can set, clear and keep different elements at once.
- R5: Configuration-low bits 5 (direction), 6 (extended identifier) and 7 (node select) write only to the shadow copy. Reads of these bits return the active copy, which is unchanged by the write.
- R6: A control write whose valid field is 2'b10 copies the shadow bits into the active copy. This happens whether the valid element was clear or set before the write. Valid codes 2'b01, 2'b11 and 2'b00 do not copy.
- R7: These fields are written and read back at once, with no staging:
  - data length code, configuration-low bits [3:0];
  - remote-monitoring bit, configuration-low bit 4;
  - receive node pointer, configuration-high bits [3:0];
  - transmit node pointer, configuration-high bits [7:4].
- R8: Control-word bits [15:8] are a plain frame counter field, written and read as data.
- R9: After reset, every control word reads 16'h0055 (all elements clear), and every configuration word reads 16'h0000.
- R10: Unused bits of the configuration words read as 0. The sub-address 3 word reads 16'h0000, and writes to it have no effect.
- R11: A write changes only the slot whose address it carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | Word address: slot in [6:2], sub-register in [1:0] |
| wr_en | input | 1 | Write strobe, word written on the rising edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr (combinational) |

## Verification
Two functions can coincide in one control write. The commit of the staged bits can happen in the same write that changes the other control elements and the frame counter. Separately, a set, a clear and a keep code can act in one write. The bench provokes these cases in three ways. It issues mixed-code control words. It commits while the valid element is already set. It issues a clear-valid write that must not commit. Each case is judged by reading back the control word and the configuration-low word, and comparing both against values worked out from the code rules.

// File: rtl/msgobj_bank_pkg.sv
package msgobj_bank_pkg;

    localparam int DATA_W  = 16;
    localparam int N_ELEMS = 4;
    localparam int DLC_W   = 4;
    localparam int PTR_W   = 4;
    localparam int FCNT_W  = DATA_W - 2 * N_ELEMS;
    localparam int CFGL_W  = DLC_W + 4;
    localparam int CFGH_W  = 2 * PTR_W;

    typedef enum logic [1:0] {
        CODE_RSVD = 2'b00,
        CODE_CLR  = 2'b01,
        CODE_SET  = 2'b10,
        CODE_KEEP = 2'b11
    } code_t;

    typedef enum logic [1:0] {
        SUB_CTRL = 2'd0,
        SUB_CFGL = 2'd1,
        SUB_CFGH = 2'd2,
        SUB_RSVD = 2'd3
    } sub_t;

    typedef struct packed {
        logic node;
        logic ext;
        logic dir;
    } staged_t;

    typedef struct packed {
        logic [PTR_W-1:0] tx_ptr;
        logic [PTR_W-1:0] rx_ptr;
        logic             rmon;
        logic [DLC_W-1:0] dlc;
    } plain_cfg_t;

    function automatic logic next_elem(input logic cur, input code_t code);
        case (code)
            CODE_SET: return 1'b1;
            CODE_CLR: return 1'b0;
            default:  return cur;
        endcase
    endfunction

    function automatic logic [1:0] read_code(input logic state);
        return state ? CODE_SET : CODE_CLR;
    endfunction

    function automatic logic ctrl_fields_legal(input logic [2*N_ELEMS-1:0] f);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N_ELEMS; i++) begin
            if (f[2*i +: 2] != CODE_CLR && f[2*i +: 2] != CODE_SET) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/msgobj_ctrl_elem.sv
module msgobj_ctrl_elem
    import msgobj_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  code_t code,
    output logic  state
);

    logic state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= 1'b0;
        else if (wr_en) state_q <= next_elem(state_q, code);
    end

    assign state = state_q;

    AST_CODE_SETS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && code == CODE_SET) |=> state) else $error("set code ignored"); // R1

    AST_CODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && code == CODE_CLR) |=> !state) else $error("clear code ignored"); // R1

    AST_CODE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (code == CODE_KEEP || code == CODE_RSVD)) |=> $stable(state))
        else $error("keep code changed element"); // R2

endmodule

// File: rtl/msgobj_slot.sv
module msgobj_slot
    import msgobj_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_cfgl,
    input  logic              wr_cfgh,
    input  logic [DATA_W-1:0] wr_ctrl_data,
    input  logic [CFGL_W-1:0] wr_cfgl_data,
    input  logic [CFGH_W-1:0] wr_cfgh_data,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [CFGL_W-1:0] cfgl_word,
    output logic [CFGH_W-1:0] cfgh_word
);

    logic [N_ELEMS-1:0] elem_state;
    logic [FCNT_W-1:0]  fcnt_q;
    staged_t            shadow_q;
    staged_t            active_q;
    plain_cfg_t         plain_q;
    logic               commit;

    // element 0 is the valid element; its code gates the commit
    generate
        for (genvar e = 0; e < N_ELEMS; e++) begin : g_elem
            msgobj_ctrl_elem i_elem (
                .clk   (clk),
                .rst   (rst),
                .wr_en (wr_ctrl),
                .code  (code_t'(wr_ctrl_data[2*e +: 2])),
                .state (elem_state[e])
            );
            assign ctrl_word[2*e +: 2] = read_code(elem_state[e]);
        end
    endgenerate

    assign ctrl_word[DATA_W-1:2*N_ELEMS] = fcnt_q;
    assign commit = wr_ctrl && (code_t'(wr_ctrl_data[1:0]) == CODE_SET);

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt_q   <= '0;
            shadow_q <= '0;
            active_q <= '0;
            plain_q  <= '0;
        end else begin
            if (wr_ctrl) fcnt_q <= wr_ctrl_data[DATA_W-1:2*N_ELEMS];
            if (wr_cfgl) begin
                plain_q.dlc   <= wr_cfgl_data[DLC_W-1:0];
                plain_q.rmon  <= wr_cfgl_data[DLC_W];
                shadow_q.dir  <= wr_cfgl_data[DLC_W+1];
                shadow_q.ext  <= wr_cfgl_data[DLC_W+2];
                shadow_q.node <= wr_cfgl_data[DLC_W+3];
            end
            if (wr_cfgh) begin
                plain_q.rx_ptr <= wr_cfgh_data[PTR_W-1:0];
                plain_q.tx_ptr <= wr_cfgh_data[CFGH_W-1:PTR_W];
            end
            if (commit) active_q <= shadow_q;
        end
    end

    assign cfgl_word = {active_q.node, active_q.ext, active_q.dir, plain_q.rmon, plain_q.dlc};
    assign cfgh_word = {plain_q.tx_ptr, plain_q.rx_ptr};

    AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active_q)) else $error("active bits moved without commit"); // R5

    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q == $past(shadow_q))) else $error("commit lost shadow value"); // R6

    AST_PLAIN_DLC: assert property (@(posedge clk) disable iff (rst)
        wr_cfgl |=> (cfgl_word[DLC_W-1:0] == $past(wr_cfgl_data[DLC_W-1:0])))
        else $error("length code not written"); // R7

    AST_FCNT_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_word[DATA_W-1:2*N_ELEMS] == $past(wr_ctrl_data[DATA_W-1:2*N_ELEMS])))
        else $error("frame counter not written"); // R8

endmodule

// File: rtl/msgobj_ctrl_bank.sv
module msgobj_ctrl_bank
    import msgobj_bank_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [SLOT_W-1:0] slot_idx;
    sub_t              sub;
    logic [DATA_W-1:0] ctrl_words [NUM_SLOTS];
    logic [CFGL_W-1:0] cfgl_words [NUM_SLOTS];
    logic [CFGH_W-1:0] cfgh_words [NUM_SLOTS];

    assign slot_idx = addr[ADDR_W-1:2];
    assign sub      = sub_t'(addr[1:0]);

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            logic hit;
            assign hit = wr_en && (slot_idx == SLOT_W'(s));
            msgobj_slot i_slot (
                .clk          (clk),
                .rst          (rst),
                .wr_ctrl      (hit && sub == SUB_CTRL),
                .wr_cfgl      (hit && sub == SUB_CFGL),
                .wr_cfgh      (hit && sub == SUB_CFGH),
                .wr_ctrl_data (wr_data),
                .wr_cfgl_data (wr_data[CFGL_W-1:0]),
                .wr_cfgh_data (wr_data[CFGH_W-1:0]),
                .ctrl_word    (ctrl_words[s]),
                .cfgl_word    (cfgl_words[s]),
                .cfgh_word    (cfgh_words[s])
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        case (sub)
            SUB_CTRL: rd_data = ctrl_words[slot_idx];
            SUB_CFGL: rd_data = DATA_W'(cfgl_words[slot_idx]);
            SUB_CFGH: rd_data = DATA_W'(cfgh_words[slot_idx]);
            default:  rd_data = '0;
        endcase
    end

    AST_CTRL_READ_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (sub == SUB_CTRL) |-> ctrl_fields_legal(rd_data[2*N_ELEMS-1:0]))
        else $error("illegal control read code"); // R3

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sub == SUB_RSVD) |-> (rd_data == '0)) else $error("reserved word not zero"); // R10

    AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sub == SUB_CFGL || sub == SUB_CFGH) |-> (rd_data[DATA_W-1:CFGL_W] == '0))
        else $error("reserved config bits set"); // R10

endmodule

// File: tb/test_msgobj_ctrl_bank.sv
module test_msgobj_ctrl_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    msgobj_ctrl_bank i_msgobj_ctrl_bank (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    // {is_write, req, addr, data-or-expected}
    localparam int NV = 25;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 4'd1,  7'd0,   16'h00FE}, // R1 set valid, keep rest
        {1'b0, 4'd1,  7'd0,   16'h0056}, // R1
        {1'b1, 4'd8,  7'd0,   16'hA5FB}, // R8 counter A5, set rx pending
        {1'b0, 4'd4,  7'd0,   16'hA55A}, // R4
        {1'b1, 4'd2,  7'd0,   16'h3C00}, // R2 all fields 00
        {1'b0, 4'd2,  7'd0,   16'h3C5A}, // R2
        {1'b1, 4'd1,  7'd0,   16'h3C77}, // R1 clear rx, clear lost
        {1'b0, 4'd1,  7'd0,   16'h3C56}, // R1
        {1'b1, 4'd5,  7'd1,   16'hFFFF}, // R5 staged bits to shadow
        {1'b0, 4'd5,  7'd1,   16'h001F}, // R5 R7
        {1'b1, 4'd6,  7'd0,   16'h3CFE}, // R6 commit while valid set
        {1'b0, 4'd6,  7'd1,   16'h00FF}, // R6
        {1'b1, 4'd5,  7'd1,   16'h0003}, // R5 shadow cleared
        {1'b0, 4'd5,  7'd1,   16'h00E3}, // R5
        {1'b1, 4'd6,  7'd0,   16'h3CFD}, // R6 clear valid: no commit
        {1'b0, 4'd6,  7'd1,   16'h00E3}, // R6
        {1'b0, 4'd3,  7'd0,   16'h3C55}, // R3
        {1'b1, 4'd6,  7'd0,   16'h3CFE}, // R6 commit from clear
        {1'b0, 4'd6,  7'd1,   16'h0003}, // R6
        {1'b1, 4'd7,  7'd2,   16'hFFFF}, // R7 pointers
        {1'b0, 4'd7,  7'd2,   16'h00FF}, // R7
        {1'b1, 4'd10, 7'd3,   16'hFFFF}, // R10 reserved word
        {1'b0, 4'd10, 7'd3,   16'h0000}, // R10
        {1'b0, 4'd11, 7'd124, 16'h0055}, // R11 slot 31 untouched
        {1'b0, 4'd11, 7'd21,  16'h0000}  // R11 slot 5 untouched
    };

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_read(input logic [6:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1;
        n_checks++;
        if (rd_data !== exp) begin
            n_errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check_read(7'd0,   16'h0055, "R9");
        check_read(7'd1,   16'h0000, "R9");
        check_read(7'd2,   16'h0000, "R9");
        check_read(7'd126, 16'h0000, "R9");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][27]) do_write(VEC[i][22:16], VEC[i][15:0]);
            else check_read(VEC[i][22:16], VEC[i][15:0], $sformatf("R%0d", VEC[i][26:23]));
        end

        // R9 reset again after activity
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check_read(7'd0, 16'h0055, "R9");
        check_read(7'd1, 16'h0000, "R9");
        check_read(7'd2, 16'h0000, "R9");

        // R4 last slot: set all four, then clear all four
        do_write(7'd124, 16'h00AA);
        check_read(7'd124, 16'h00AA, "R4");
        do_write(7'd124, 16'h0055);
        check_read(7'd124, 16'h0055, "R1");

        // R5/R6 last slot: stage ext and node, commit with valid set
        do_write(7'd125, 16'h00C0);
        check_read(7'd125, 16'h0000, "R5");
        do_write(7'd124, 16'hFFFF);
        check_read(7'd125, 16'h0000, "R6 keep code no commit");
        do_write(7'd124, 16'h00FE);
        check_read(7'd125, 16'h00C0, "R6");
        check_read(7'd124, 16'h0056, "R3");
        // R11 slot 0 unaffected
        check_read(7'd1, 16'h0000, "R11");
        // R10 write to reserved word of last slot
        do_write(7'd127, 16'h1234);
        check_read(7'd127, 16'h0000, "R10");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule